// File: doc/BRIEF.md
# Indirect Redirection Register Window

This block is the register file of an interrupt router. Software sees only two 32-bit words on a small synchronous bus. One is a select register. The other is a data window. The select value picks one of three things behind the window: an identification register, a fixed version word, or one half of a 64-bit redirection entry. There is one redirection entry per interrupt pin. To change an entry, software writes the select register with the number of the half it wants, then reads or writes the window.

The block drives each entry's routing fields to the delivery logic next to it. These are the vector, delivery mode, destination mode, trigger mode, mask and destination. Each entry also has two status bits that the delivery logic owns. Remote-IRR is set and cleared by strobes. Delivery status follows a level input. A software write can never overwrite these two bits. When a write leaves an entry in edge mode, its remote-IRR bit is cleared. When a write changes an entry's mask bit, the block raises a one-cycle event that carries the pin number and the new mask value.

Top module: `irq_redir_window`

## Requirements
- R1: A write to the select offset (0x00) stores data bits 7:0. A read at that offset returns the stored value in bits 7:0, with zeros above.
- R2: Select 0x01 reads the version word: (NPINS-1) in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Window writes with this select change nothing.
- R3: Select 0x00 holds a 4-bit ID at window bits 27:24, for both read and write. Select 0x02 reads the same ID in the same place, and window writes with select 0x02 leave the ID unchanged.
- R4: For selects of 0x10 and above, the entry index is (select - 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. The entry fields are laid out as follows, and each entry drives its fields on the matching output ports:
  - vector in bits 7:0
  - delivery mode in bits 10:8
  - destination mode in bit 11
  - delivery status in bit 12
  - remote-IRR in bit 14
  - trigger mode in bit 15 (1 = level, 0 = edge)
  - mask in bit 16
  - destination in bits 63:56
- R5: The window reads 0xFFFFFFFF, and window writes change nothing, for an index at or beyond NPINS and for selects 0x03 to 0x0F.
- R6: A window write replaces only the addressed half of the entry. Bits 12 and 14 of the write data are discarded. Delivery status and remote-IRR keep their values from the delivery logic.
- R7: After a window write to either half of an entry, if the entry's trigger mode is edge (bit 15 = 0), its remote-IRR bit is 0. This holds even if a remote-IRR set strobe arrives in the same cycle.
- R8: Reset does the following:
  - sets every entry's mask bit
  - clears all other entry bits
  - clears the select register and the ID
- R9: Bus offsets other than 0x00 and 0x10 read as zero. Writes to them change nothing.
- R10: One cycle after a window write that changes an entry's mask bit, mask_evt is high for exactly one cycle, with mask_pin set to the entry index and mask_val set to the new mask value. A write that leaves the mask bit unchanged raises no event.
- R11: A pulse on rirr_set[i] sets entry i's remote-IRR, and a pulse on rirr_clr[i] clears it; if both arrive together, set wins. A software write that leaves the entry in level mode does not block either strobe. The delivery-status bit of entry i takes the value of dstat_in[i] one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rirr_set | input | NPINS | Per-pin remote-IRR set strobe |
| rirr_clr | input | NPINS | Per-pin remote-IRR clear strobe |
| dstat_in | input | NPINS | Per-pin delivery-status level |
| ent_vector | output | NPINS*8 | Vector field of each entry |
| ent_dmode | output | NPINS*3 | Delivery mode of each entry |
| ent_destm | output | NPINS | Destination mode of each entry |
| ent_trig | output | NPINS | Trigger mode of each entry (1 = level) |
| ent_mask | output | NPINS | Mask bit of each entry |
| ent_rirr | output | NPINS | Remote-IRR bit of each entry |
| ent_dest | output | NPINS*8 | Destination field of each entry |
| mask_evt | output | 1 | One-cycle mask-change event |
| mask_pin | output | PW | Entry index of the mask change |
| mask_val | output | 1 | New mask value |

## Verification
A software window write and a remote-IRR strobe from the delivery logic can hit the same entry in the same clock edge. The bench provokes this by raising rirr_set for a pin in the exact cycle it writes that pin's lower half: once with level mode, and once with edge mode. The result is read back both on ent_rirr and through the window. In level mode the strobe must win and remote-IRR reads 1. In edge mode the forced clear must win and remote-IRR reads 0.

// File: rtl/irq_redir_window.sv
module irq_redir_window #(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int AW = 8,
  parameter logic [AW-1:0] SEL_OFF = 8'h00,
  parameter logic [AW-1:0] WIN_OFF = 8'h10,
  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   rirr_set,
  input  logic [NPINS-1:0]   rirr_clr,
  input  logic [NPINS-1:0]   dstat_in,
  output logic [NPINS*8-1:0] ent_vector,
  output logic [NPINS*3-1:0] ent_dmode,
  output logic [NPINS-1:0]   ent_destm,
  output logic [NPINS-1:0]   ent_trig,
  output logic [NPINS-1:0]   ent_mask,
  output logic [NPINS-1:0]   ent_rirr,
  output logic [NPINS*8-1:0] ent_dest,
  output logic               mask_evt,
  output logic [PW-1:0]      mask_pin,
  output logic               mask_val
);
  localparam logic [7:0]  LAST_PIN = 8'(NPINS - 1);
  localparam logic [63:0] ENT_RST  = 64'h0000_0000_0001_0000;

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic [63:0] ent_q [NPINS];
  logic [63:0] ent_d [NPINS];
  logic [63:0] cur, merged;

  wire sel_hit = (bus_addr == SEL_OFF);
  wire win_hit = (bus_addr == WIN_OFF);
  wire [6:0] idx = sel_q[7:1] - 7'd8;
  wire idx_ok = (sel_q >= 8'h10) && (idx < 7'(NPINS));
  wire tbl_we = bus_we && win_hit && idx_ok;
  wire [PW-1:0] pin = idx[PW-1:0];

  always_comb begin
    cur = '1;
    for (int i = 0; i < NPINS; i++)
      if (idx_ok && idx == 7'(i)) cur = ent_q[i];
  end

  assign merged = sel_q[0] ? {bus_wdata, cur[31:0]} : {cur[63:32], bus_wdata};

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      ent_d[i] = ent_q[i];
      if (tbl_we && idx == 7'(i)) ent_d[i] = merged;
      ent_d[i][12] = dstat_in[i];
      if (tbl_we && idx == 7'(i) && !merged[15]) ent_d[i][14] = 1'b0;
      else if (rirr_set[i])                      ent_d[i][14] = 1'b1;
      else if (rirr_clr[i])                      ent_d[i][14] = 1'b0;
      else                                       ent_d[i][14] = ent_q[i][14];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      id_q     <= '0;
      mask_evt <= 1'b0;
      mask_pin <= '0;
      mask_val <= 1'b0;
      for (int i = 0; i < NPINS; i++) ent_q[i] <= ENT_RST;
    end else begin
      if (bus_we && sel_hit) sel_q <= bus_wdata[7:0];
      if (bus_we && win_hit && sel_q == 8'h00) id_q <= bus_wdata[27:24];
      mask_evt <= tbl_we && (merged[16] != cur[16]);
      mask_pin <= pin;
      mask_val <= merged[16];
      for (int i = 0; i < NPINS; i++) ent_q[i] <= ent_d[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_hit) bus_rdata = {24'h0, sel_q};
    else if (win_hit) begin
      if (sel_q == 8'h00 || sel_q == 8'h02) bus_rdata = {4'h0, id_q, 24'h0};
      else if (sel_q == 8'h01)              bus_rdata = {8'h0, LAST_PIN, 8'h0, VERSION};
      else                                  bus_rdata = sel_q[0] ? cur[63:32] : cur[31:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      localparam logic [7:0] SEL_LO = 8'(16 + 2 * g);
      assign ent_vector[g*8 +: 8] = ent_q[g][7:0];
      assign ent_dmode[g*3 +: 3]  = ent_q[g][10:8];
      assign ent_destm[g]         = ent_q[g][11];
      assign ent_rirr[g]          = ent_q[g][14];
      assign ent_trig[g]          = ent_q[g][15];
      assign ent_mask[g]          = ent_q[g][16];
      assign ent_dest[g*8 +: 8]   = ent_q[g][63:56];

      a_r7_edge_write_clears_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && win_hit && sel_q == SEL_LO && !bus_wdata[15]) |=> !ent_rirr[g]);

      a_r6_level_write_keeps_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && win_hit && sel_q == SEL_LO && bus_wdata[15] && !rirr_set[g] && !rirr_clr[g])
        |=> ent_rirr[g] == $past(ent_rirr[g]));

      a_r11_set_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set[g] && !(bus_we && win_hit && sel_q[7:1] == 7'(8 + g))) |=> ent_rirr[g]);
    end
  endgenerate

  a_r10_evt_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> $past(bus_we && win_hit));

  a_r5_far_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && win_hit && int'(sel_q) >= 16 + 2 * NPINS)
    |=> ($stable(ent_mask) && $stable(ent_vector) && $stable(ent_dest) && !mask_evt));

  a_r3_arb_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && win_hit && sel_q == 8'h02) |=> $stable(id_q));

  a_r9_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !sel_hit && !win_hit) |=> ($stable(sel_q) && $stable(id_q) && !mask_evt));
endmodule

// File: tb/irq_redir_window_tb.sv
module irq_redir_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] rirr_set = '0, rirr_clr = '0, dstat_in = '0;
  logic [NP*8-1:0] ent_vector, ent_dest;
  logic [NP*3-1:0] ent_dmode;
  logic [NP-1:0] ent_destm, ent_trig, ent_mask, ent_rirr;
  logic mask_evt, mask_val;
  logic [PW-1:0] mask_pin;

  int checks = 0, errors = 0;
  logic ev, evv;
  logic [PW-1:0] evp;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redir_window #(.NPINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rirr_set(rirr_set),
    .rirr_clr(rirr_clr), .dstat_in(dstat_in), .ent_vector(ent_vector),
    .ent_dmode(ent_dmode), .ent_destm(ent_destm), .ent_trig(ent_trig),
    .ent_mask(ent_mask), .ent_rirr(ent_rirr), .ent_dest(ent_dest),
    .mask_evt(mask_evt), .mask_pin(mask_pin), .mask_val(mask_val));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [NP-1:0] s = '0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; rirr_set = s;
    @(posedge clk); #1;
    ev = mask_evt; evp = mask_pin; evv = mask_val;
    bus_we = 1'b0; rirr_set = '0;
  endtask

  task automatic rdw(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic hw(input logic [NP-1:0] s, input logic [NP-1:0] c);
    @(negedge clk);
    rirr_set = s; rirr_clr = c;
    @(posedge clk); #1;
    rirr_set = '0; rirr_clr = '0;
  endtask

  task automatic rd_sel(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'h0, s});
    rdw(8'h10, d);
  endtask

  task automatic t_reset;
    rdw(8'h00, rd); chk("R8 select after reset", rd, 32'h0);
    rdw(8'h10, rd); chk("R8 id after reset", rd, 32'h0);
    chk("R8 masks after reset", 32'(ent_mask), 32'(24'hFF_FFFF));
    rd_sel(8'h10, rd); chk("R8 entry0 low", rd, 32'h0001_0000);
    rd_sel(8'h11, rd); chk("R8 entry0 high", rd, 32'h0);
  endtask

  task automatic t_select;
    wr(8'h00, 32'h0000_01A5);
    rdw(8'h00, rd); chk("R1 select readback", rd, 32'h0000_00A5);
  endtask

  task automatic t_version;
    rd_sel(8'h01, rd); chk("R2 version", rd, 32'h0017_0011);
    wr(8'h10, 32'hFFFF_FFFF);
    rdw(8'h10, rd); chk("R2 version after write", rd, 32'h0017_0011);
  endtask

  task automatic t_id;
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hFA00_0000);
    rdw(8'h10, rd); chk("R3 id", rd, 32'h0A00_0000);
    rd_sel(8'h02, rd); chk("R3 arb reads id", rd, 32'h0A00_0000);
    wr(8'h10, 32'h0500_0000);
    rd_sel(8'h00, rd); chk("R3 arb write ignored", rd, 32'h0A00_0000);
  endtask

  task automatic t_entry;
    wr(8'h00, 32'h1A);
    wr(8'h10, 32'h0000_F9C3);
    chk("R10 evt on unmask", {31'h0, ev}, 32'h1);
    chk("R10 evt pin", 32'(evp), 32'd5);
    chk("R10 evt value", {31'h0, evv}, 32'h0);
    @(posedge clk); #1;
    chk("R10 evt one cycle", {31'h0, mask_evt}, 32'h0);
    rdw(8'h10, rd); chk("R6 status bits kept", rd, 32'h0000_A9C3);
    chk("R4 vector out", 32'(ent_vector[5*8 +: 8]), 32'hC3);
    chk("R4 dmode out", 32'(ent_dmode[5*3 +: 3]), 32'h1);
    chk("R4 fields out", {28'h0, ent_destm[5], ent_trig[5], ent_mask[5], ent_rirr[5]}, 32'hC);
    wr(8'h00, 32'h1B);
    wr(8'h10, 32'hB700_0000);
    chk("R10 no evt on high write", {31'h0, ev}, 32'h0);
    rdw(8'h10, rd); chk("R4 high half", rd, 32'hB700_0000);
    chk("R4 dest out", 32'(ent_dest[5*8 +: 8]), 32'hB7);
    rd_sel(8'h1A, rd); chk("R6 low half untouched", rd, 32'h0000_A9C3);
  endtask

  task automatic t_rirr;
    hw(NP'(1) << 5, '0);
    chk("R11 set strobe", {31'h0, ent_rirr[5]}, 32'h1);
    rd_sel(8'h1A, rd); chk("R11 rirr visible", rd, 32'h0000_E9C3);
    wr(8'h10, 32'h0000_A9C3);
    chk("R10 no evt mask same", {31'h0, ev}, 32'h0);
    rdw(8'h10, rd); chk("R6 rirr survives write", rd, 32'h0000_E9C3);
    @(negedge clk); dstat_in = NP'(1) << 5;
    @(posedge clk); #1;
    rdw(8'h10, rd); chk("R11 dstat follows", rd, 32'h0000_F9C3);
    @(negedge clk); dstat_in = '0;
    hw((NP'(1) << 5), (NP'(1) << 5));
    chk("R11 set beats clear", {31'h0, ent_rirr[5]}, 32'h1);
    hw('0, NP'(1) << 5);
    chk("R11 clear strobe", {31'h0, ent_rirr[5]}, 32'h0);
  endtask

  task automatic t_edge;
    hw(NP'(1) << 5, '0);
    wr(8'h00, 32'h1A);
    wr(8'h10, 32'h0000_29C3);
    chk("R7 edge write clears rirr", {31'h0, ent_rirr[5]}, 32'h0);
    wr(8'h10, 32'h0000_A9C3, NP'(1) << 5);
    chk("R11 level write with set", {31'h0, ent_rirr[5]}, 32'h1);
    rdw(8'h10, rd); chk("R11 window shows rirr", rd, 32'h0000_E9C3);
    wr(8'h10, 32'h0000_29C3, NP'(1) << 5);
    chk("R7 edge write beats set", {31'h0, ent_rirr[5]}, 32'h0);
    rdw(8'h10, rd); chk("R7 window rirr clear", rd, 32'h0000_29C3);
  endtask

  task automatic t_range;
    wr(8'h00, 32'h3E);
    wr(8'h10, 32'h0000_0042);
    chk("R4 last pin evt", {31'h0, ev}, 32'h1);
    chk("R4 last pin index", 32'(evp), 32'd23);
    rdw(8'h10, rd); chk("R4 last pin low", rd, 32'h0000_0042);
    wr(8'h00, 32'h40);
    rdw(8'h10, rd); chk("R5 beyond read", rd, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0);
    chk("R5 beyond write no evt", {31'h0, ev}, 32'h0);
    rd_sel(8'h41, rd); chk("R5 beyond high", rd, 32'hFFFF_FFFF);
    rd_sel(8'h05, rd); chk("R5 gap select read", rd, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0);
    rd_sel(8'hFF, rd); chk("R5 top select read", rd, 32'hFFFF_FFFF);
    chk("R5 masks unchanged", 32'(ent_mask), 32'(24'h7F_FFDF));
  endtask

  task automatic t_other;
    wr(8'h00, 32'h33);
    rdw(8'h04, rd); chk("R9 stray read zero", rd, 32'h0);
    wr(8'h20, 32'h55);
    rdw(8'h00, rd); chk("R9 stray write ignored", rd, 32'h33);
  endtask

  task automatic t_reset2;
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst_n = 1'b1;
    chk("R8 masks after rerun reset", 32'(ent_mask), 32'(24'hFF_FFFF));
    chk("R8 rirr after reset", 32'(ent_rirr), 32'h0);
    rdw(8'h00, rd); chk("R8 select cleared", rd, 32'h0);
    rdw(8'h10, rd); chk("R8 id cleared", rd, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_select;
    t_version;
    t_id;
    t_entry;
    t_rirr;
    t_edge;
    t_range;
    t_other;
    t_reset2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule